// File: doc/BRIEF.md
# Vectored Interrupt Controller with Per-Input Edge or Level Sensing

The block gathers up to 32 interrupt request lines and merges them into one request line to a processor. Each line is captured into a sticky status bit. Whether a line is captured on its rising edge or on its level is fixed per line at elaboration by a bit mask parameter. Each status bit is gated by an enable bit to form a pending bit. A combined request output is raised when the master switch is on and any bit is pending. Software reads the number of the lowest pending line from a vector register, and it reads all ones when nothing is pending.

Software reaches the block through a single-cycle 32-bit register port with a byte address. Enable bits can be written as a whole word. They can also be set or cleared in place through two atomic registers, so no read-modify-write is needed. Status bits are acknowledged by writing ones. A control register holds the master switch and a one-way lock. Until the lock is set, software may write to the status register to inject test interrupts.

Top module: `vic_top`

## Requirements
- R1: After synchronous reset, status, enable, pending and control read as zero, the vector reads 0xFFFFFFFF and `irq_out` is low.
- R2: An edge-sensing input (its bit in `KIND_MASK` is one) sets its status bit on the clock edge where it is seen high after being low in the previous cycle. An acknowledge while the input stays high leaves the bit clear.
- R3: A level-sensing input (its bit in `KIND_MASK` is zero) sets its status bit on every edge where it is high. An acknowledge while it stays high is overridden, and the bit reads set again.
- R4: A write to byte offset 0x0C clears every status bit where the written word has a one. A write of 0xFFFFFFFF clears them all.
- R5: A write to offset 0x10 sets each enable bit where the word has a one and leaves the other enable bits unchanged.
- R6: A write to offset 0x14 clears each enable bit where the word has a one and leaves the other enable bits unchanged.
- R7: A write to offset 0x08 replaces the enable register, and a read of 0x08 returns it. A write of zero disables every input.
- R8: A read of offset 0x04 returns status AND enable. A read of offset 0x00 returns status.
- R9: A read of offset 0x18 returns the index of the lowest-numbered pending bit, or 0xFFFFFFFF if no bit is pending.
- R10: `irq_out` is registered. It is high one cycle after a cycle in which control bit 0 is one and some bit is pending, and low one cycle after any other cycle.
- R11: Control register at offset 0x1C: bit 0 is the master switch and reads back as written. Bit 1 is the lock. It reads back once written with one, and after that only reset clears it.
- R12: While the lock is zero, a write to offset 0x00 sets the status bits where the word has a one. Once the lock is one, such a write leaves status unchanged.
- R13: Reads of offsets 0x0C, 0x10 and 0x14 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IN | Interrupt request lines |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 5 | Byte offset of the register, shared by read and write |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| irq_out | output | 1 | Registered interrupt request to the processor |

## Verification
The assertions assume that `addr` and `wdata` are stable whenever `wr_en` is sampled, and that a write lasts exactly the one cycle in which the strobe is high. The bench meets this by driving all inputs on the falling edge, so each value is held through the following rising edge. Request lines may change in any cycle and in any pattern, and the properties about the vector and the output hold for all of them. Random operations mix all eight offsets with sparse random request patterns. Writes are limited to the register offsets, so no reserved address is ever written.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 5;

    // word index = addr[4:2]; the order is the software-visible map
    typedef enum logic [2:0] {
        SEL_STATUS = 3'd0,
        SEL_PEND   = 3'd1,
        SEL_ENABLE = 3'd2,
        SEL_ACK    = 3'd3,
        SEL_SETEN  = 3'd4,
        SEL_CLREN  = 3'd5,
        SEL_VECTOR = 3'd6,
        SEL_CTRL   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic hw_lock;    // bit 1
        logic master_on;  // bit 0
    } ctrl_t;

    function automatic reg_sel_e decode_sel(input logic [ADDR_W-1:0] a);
        return reg_sel_e'(a[4:2]);
    endfunction

endpackage

// File: rtl/irqc_sense.sv
module irqc_sense #(
    parameter int unsigned NUM_IN    = 8,
    parameter logic [31:0] KIND_MASK = 32'h0000_000F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] irq_in,
    output logic [NUM_IN-1:0] hits
);

    for (genvar g = 0; g < NUM_IN; g++) begin : g_line
        if (KIND_MASK[g]) begin : g_edge
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= irq_in[g];
            end
            assign hits[g] = irq_in[g] & ~prev_q;
        end else begin : g_level
            assign hits[g] = irq_in[g];
        end
    end

endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
    parameter int unsigned NUM_IN = 8
) (
    input  logic [NUM_IN-1:0] pend,
    output logic [31:0]       vec,
    output logic              any
);

    always_comb begin
        vec = '1;
        any = 1'b0;
        for (int i = NUM_IN - 1; i >= 0; i--) begin
            if (pend[i]) begin
                vec = 32'(i);
                any = 1'b1;
            end
        end
    end

endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IN = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_IN-1:0] hits,
    input  logic              wr_en,
    input  reg_sel_e          sel,
    input  logic [NUM_IN-1:0] wbits,
    input  logic [1:0]        wctrl,
    output logic [NUM_IN-1:0] status,
    output logic [NUM_IN-1:0] enable,
    output ctrl_t             ctrl
);

    logic [NUM_IN-1:0] ack_clr;
    logic [NUM_IN-1:0] sw_set;

    always_comb begin
        ack_clr = (wr_en && sel == SEL_ACK) ? wbits : '0;
        sw_set  = (wr_en && sel == SEL_STATUS && !ctrl.hw_lock) ? wbits : '0;
    end

    // new hits win over an acknowledge in the same cycle
    always_ff @(posedge clk) begin
        if (rst) status <= '0;
        else     status <= (status & ~ack_clr) | hits | sw_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= '0;
        end else if (wr_en) begin
            case (sel)
                SEL_ENABLE: enable <= wbits;
                SEL_SETEN:  enable <= enable | wbits;
                SEL_CLREN:  enable <= enable & ~wbits;
                default:    enable <= enable;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_en && sel == SEL_CTRL) begin
            ctrl.master_on <= wctrl[0];
            ctrl.hw_lock   <= ctrl.hw_lock | wctrl[1];
        end
    end

endmodule

// File: rtl/vic_top.sv
module vic_top
    import irqc_pkg::*;
#(
    parameter int unsigned NUM_IN    = 8,
    parameter logic [31:0] KIND_MASK = 32'h0000_000F
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_IN-1:0]   irq_in,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    output logic [DATA_W-1:0]   rd_data,
    output logic                irq_out
);

    reg_sel_e          sel;
    logic [NUM_IN-1:0] hits;
    logic [NUM_IN-1:0] status;
    logic [NUM_IN-1:0] enable;
    logic [NUM_IN-1:0] pend;
    logic [31:0]       vec;
    logic              any_pend;
    ctrl_t             ctrl;

    wire unused_bus = ^{wdata, addr[1:0]};

    assign sel = decode_sel(addr);

    irqc_sense #(.NUM_IN(NUM_IN), .KIND_MASK(KIND_MASK)) u_sense (
        .clk    (clk),
        .rst    (rst),
        .irq_in (irq_in),
        .hits   (hits)
    );

    irqc_regs #(.NUM_IN(NUM_IN)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .hits   (hits),
        .wr_en  (wr_en),
        .sel    (sel),
        .wbits  (wdata[NUM_IN-1:0]),
        .wctrl  (wdata[1:0]),
        .status (status),
        .enable (enable),
        .ctrl   (ctrl)
    );

    assign pend = status & enable;

    irqc_prio #(.NUM_IN(NUM_IN)) u_prio (
        .pend (pend),
        .vec  (vec),
        .any  (any_pend)
    );

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= ctrl.master_on & any_pend;
    end

    always_comb begin
        rd_data = '0;
        case (sel)
            SEL_STATUS: rd_data[NUM_IN-1:0] = status;
            SEL_PEND:   rd_data[NUM_IN-1:0] = pend;
            SEL_ENABLE: rd_data[NUM_IN-1:0] = enable;
            SEL_VECTOR: rd_data = vec;
            SEL_CTRL:   rd_data[1:0] = ctrl;
            default:    rd_data = '0;
        endcase
    end

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
    parameter int unsigned NUM_IN = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              irq_out,
    input logic [NUM_IN-1:0] pend,
    input logic [31:0]       vec,
    input logic [NUM_IN-1:0] enable,
    input logic              lock,
    input logic              master,
    input logic              wr_en,
    input logic [4:0]        addr,
    input logic [31:0]       wdata
);

    // R10: output follows master switch and pending one cycle later
    a_r10_out_high: assert property (@(posedge clk) disable iff (rst)
        (master && pend != '0) |=> irq_out);
    a_r10_out_low: assert property (@(posedge clk) disable iff (rst)
        (!master || pend == '0) |=> !irq_out);

    // R9: vector value against pending bits
    a_r9_vec_none: assert property (@(posedge clk) disable iff (rst)
        (pend == '0) |-> (vec == 32'hFFFF_FFFF));
    a_r9_vec_hit: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> (pend[vec[4:0]] == 1'b1));
    a_r9_vec_lowest: assert property (@(posedge clk) disable iff (rst)
        (pend != '0) |-> ((pend & ~({NUM_IN{1'b1}} << vec[4:0])) == '0));

    // R11: lock is one-way
    a_r11_lock_sticky: assert property (@(posedge clk) disable iff (rst)
        lock |=> lock);

    // R5 / R6: atomic enable updates
    a_r5_set_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[4:2] == 3'd4) |=>
        ((enable & $past(wdata[NUM_IN-1:0])) == $past(wdata[NUM_IN-1:0])));
    a_r6_clr_enable: assert property (@(posedge clk) disable iff (rst)
        (wr_en && addr[4:2] == 3'd5) |=>
        ((enable & $past(wdata[NUM_IN-1:0])) == '0));

endmodule

bind vic_top vic_checker #(.NUM_IN(NUM_IN)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .irq_out (irq_out),
    .pend    (pend),
    .vec     (vec),
    .enable  (enable),
    .lock    (ctrl.hw_lock),
    .master  (ctrl.master_on),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata)
);

// File: tb/sim_vic_top.sv
module sim_vic_top;

    localparam int          N      = 8;
    localparam logic [31:0] KIND   = 32'h0000_000F;
    localparam time         PERIOD = 10;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  irq_in = '0;
    logic          wr_en = 1'b0;
    logic [4:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rd_data;
    logic          irq_out;

    int total = 0;
    int bad   = 0;

    // reference state
    logic [N-1:0] m_st, m_en, m_prev;
    logic         m_me, m_lock, m_irq;

    vic_top #(.NUM_IN(N), .KIND_MASK(KIND)) u0 (
        .clk(clk), .rst(rst), .irq_in(irq_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rd_data(rd_data), .irq_out(irq_out)
    );

    always #(PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pad(input logic [N-1:0] x);
        logic [31:0] t;
        t = '0;
        t[N-1:0] = x;
        return t;
    endfunction

    function automatic logic [31:0] exp_vec();
        logic [31:0] v;
        logic [N-1:0] p;
        v = 32'hFFFF_FFFF;
        p = m_st & m_en;
        for (int i = N - 1; i >= 0; i--) if (p[i]) v = 32'(i);
        return v;
    endfunction

    function automatic logic [31:0] exp_read(input logic [4:0] a);
        case (a[4:2])
            3'd0: return pad(m_st);
            3'd1: return pad(m_st & m_en);
            3'd2: return pad(m_en);
            3'd6: return exp_vec();
            3'd7: return {30'b0, m_lock, m_me};
            default: return 32'h0;
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        m_st = '0; m_en = '0; m_prev = '0; m_me = 0; m_lock = 0; m_irq = 0;
    endtask

    // one clock cycle: drive, check current state, advance the model
    task automatic step(input logic [N-1:0] in, input logic we, input logic [4:0] a,
                        input logic [31:0] d, input string tag);
        logic [N-1:0] hit, clr, sws, en_n, st_n;
        logic me_n, lock_n, irq_n;
        @(negedge clk);
        irq_in = in; wr_en = we; addr = a; wdata = d;
        #1;
        if (!we) check(tag, rd_data, exp_read(a));
        check({tag, " R10 irq_out"}, {31'b0, irq_out}, {31'b0, m_irq});
        for (int i = 0; i < N; i++)
            hit[i] = KIND[i] ? (in[i] & ~m_prev[i]) : in[i];
        clr = (we && a[4:2] == 3'd3) ? d[N-1:0] : '0;
        sws = (we && a[4:2] == 3'd0 && !m_lock) ? d[N-1:0] : '0;
        st_n = (m_st & ~clr) | hit | sws;
        en_n = m_en;
        if (we && a[4:2] == 3'd2) en_n = d[N-1:0];
        if (we && a[4:2] == 3'd4) en_n = m_en | d[N-1:0];
        if (we && a[4:2] == 3'd5) en_n = m_en & ~d[N-1:0];
        me_n = m_me; lock_n = m_lock;
        if (we && a[4:2] == 3'd7) begin me_n = d[0]; lock_n = m_lock | d[1]; end
        irq_n = m_me & (|(m_st & m_en));
        @(posedge clk);
        m_st = st_n; m_en = en_n; m_me = me_n; m_lock = lock_n; m_irq = irq_n; m_prev = in;
    endtask

    task automatic rd(input logic [N-1:0] in, input logic [4:0] a, input string tag);
        step(in, 1'b0, a, 32'h0, tag);
    endtask

    task automatic wr(input logic [N-1:0] in, input logic [4:0] a, input logic [31:0] d,
                      input string tag);
        step(in, 1'b1, a, d, tag);
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1 and R13: reset values of every offset
        for (int k = 0; k < 8; k++) rd('0, 5'(k * 4), "R1 R13 reset read");

        // R5, R6, R7: enable writes
        wr('0, 5'h10, 32'h05, "R5");      rd('0, 5'h08, "R5 set-enable");
        wr('0, 5'h10, 32'h02, "R5");      rd('0, 5'h08, "R5 set keeps others");
        wr('0, 5'h14, 32'h01, "R6");      rd('0, 5'h08, "R6 clear-enable");
        wr('0, 5'h08, 32'hF0, "R7");      rd('0, 5'h08, "R7 direct write");
        wr('0, 5'h08, 32'h00, "R7");      rd('0, 5'h08, "R7 zero disables");
        wr('0, 5'h08, 32'hFF, "R7");

        // R2: edge input 0 held high, acked while high
        rd(8'h01, 5'h00, "R2 edge sets");
        rd(8'h01, 5'h00, "R2 edge holds");
        wr(8'h01, 5'h0C, 32'h01, "R2");
        rd(8'h01, 5'h00, "R2 no re-set while high");
        rd(8'h00, 5'h00, "R2 after release");

        // R3: level input 4 acked while high
        rd(8'h10, 5'h00, "R3 level sets");
        wr(8'h10, 5'h0C, 32'h10, "R3");
        rd(8'h10, 5'h00, "R3 re-set after ack");
        rd(8'h00, 5'h04, "R8 pending read");

        // R4: clear all
        wr('0, 5'h0C, 32'hFFFF_FFFF, "R4");
        rd('0, 5'h00, "R4 all cleared");

        // R12 (unlocked) and R9
        wr('0, 5'h00, 32'h28, "R12");
        rd('0, 5'h00, "R12 test write sets status");
        rd('0, 5'h18, "R9 lowest index");
        wr('0, 5'h14, 32'h08, "R6");
        rd('0, 5'h18, "R9 next index");
        rd('0, 5'h04, "R8 pending masked");
        wr('0, 5'h08, 32'h00, "R7");
        rd('0, 5'h18, "R9 none pending all ones");

        // R10: master switch gates the output
        wr('0, 5'h08, 32'hFF, "R7");
        rd('0, 5'h00, "R10 master off");
        wr('0, 5'h1C, 32'h1, "R10");
        rd('0, 5'h1C, "R11 master readback");
        rd('0, 5'h00, "R10 output high");
        wr('0, 5'h0C, 32'hFF, "R4");
        rd('0, 5'h00, "R10 output falls");

        // random mix
        for (int n = 0; n < 600; n++) begin
            logic [N-1:0] in;
            logic [31:0]  d;
            int           op;
            in = (($urandom % 4) == 0) ? N'($urandom) : '0;
            d  = $urandom;
            op = int'($urandom % 10);
            case (op)
                0, 1, 2, 3: rd(in, 5'(($urandom % 8) * 4), "R8 R9 random read");
                4: wr(in, 5'h08, d, "R7 random");
                5: wr(in, 5'h10, d, "R5 random");
                6: wr(in, 5'h14, d, "R6 random");
                7: wr(in, 5'h0C, d, "R4 random");
                8: wr(in, 5'h00, d, "R12 random");
                default: wr(in, 5'h1C, {30'b0, 1'b0, d[0]}, "R11 random");
            endcase
        end

        // R11 and R12: lock is one-way, test writes ignored afterwards
        wr('0, 5'h0C, 32'hFFFF_FFFF, "R4");
        wr('0, 5'h1C, 32'h3, "R11");
        rd('0, 5'h1C, "R11 both bits");
        wr('0, 5'h1C, 32'h0, "R11");
        rd('0, 5'h1C, "R11 lock sticky");
        wr('0, 5'h00, 32'h80, "R12");
        rd('0, 5'h00, "R12 write ignored when locked");
        rd('0, 5'h18, "R9 still none");

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule